// File: doc/BRIEF.md
# Comparator Output Conditioning Logic

This block is the digital back end of an analog voltage comparator. It takes the raw, asynchronous decision bit from the analog stage, brings it into the clock domain, undoes the inversion caused by swapping the comparator inputs, optionally removes glitches with a stepped-delay digital filter, applies an output polarity, and then gates the result with an enable. The conditioned level drives a pair of sticky interrupt flags that fire on opposite edges, and a reference-select line that switches the analog reference for hysteresis.

Software programs the behaviour through one 16-bit control word and reads it back together with a read-only copy of the conditioned output. The flags are cleared by single-cycle clear pulses. The reference-source field of the analog multiplexer arrives as a plain input, and the reference-select line is active only for the source codes that use the internal reference pair.

Top module: `cmp_out_cond`

## Requirements
- R1: The raw comparator bit passes through a two-flop synchroniser and an output register, so with the filter bypassed a change of `cmp_raw` shows on `cond_out` after exactly the third rising clock edge.
- R2: The exchange bit (control bit 1) inverts the synchronised comparator level before filtering.
- R3: The polarity bit (control bit 2) inverts the level after filtering when 1 and passes it unchanged when 0.
- R4: When the filter enable (control bit 3) is 1 and the power-mode field (bits 7:6) is 00 or 01, the filtered level takes a new value only after the exchanged level has differed from it for the selected count of consecutive cycles; a shorter excursion leaves the output unchanged.
- R5: With power-mode 10 or 11 the filter is bypassed whatever the filter-enable bit holds.
- R6: The delay field (bits 5:4) selects a count of 7, 14, 29 or 58 cycles for codes 00, 01, 10 and 11; each change of `cmp_raw` then reaches `cond_out` after count+3 edges.
- R7: With edge-select (bit 8) at 0, `flag_main` sets one cycle after a rising `cond_out` and `flag_inv` one cycle after a falling one; with edge-select at 1 the two are exchanged.
- R8: Changing edge-select creates an apparent edge on the current output level: writing it from 0 to 1 while `cond_out` is 0 sets `flag_main` one cycle after the write.
- R9: Flags are sticky until a one-cycle clear pulse (`clr_main`, `clr_inv`); a set condition in the same cycle as a clear leaves the flag set.
- R10: With reference-source not 11, `ref_sel` follows `cond_out` when the manual bit (bit 9) is 0, and follows the manual level bit (bit 10) when it is 1 (0 = reference 0, 1 = reference 1).
- R11: With reference-source 11, `ref_sel` is 0.
- R12: With the enable bit (bit 0) at 0, `cond_out` is 0 and neither flag sets.
- R13: `ctl_rdata` returns written bits 10:0, zeros in bits 14:11 and the conditioned output in bit 15; writing bit 15 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw, asynchronous decision bit from the analog comparator |
| ref_src | input | 2 | Reference-source field of the analog multiplexer |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word readback with output status in bit 15 |
| clr_main | input | 1 | One-cycle clear of the main flag |
| clr_inv | input | 1 | One-cycle clear of the inverted-edge flag |
| cond_out | output | 1 | Conditioned comparator output |
| flag_main | output | 1 | Main edge flag |
| flag_inv | output | 1 | Opposite-edge flag |
| ref_sel | output | 1 | Reference select: 0 = reference 0, 1 = reference 1 |

## Verification
The flag-setting edge and a software clear can fall in the same cycle. The bench raises `cmp_raw`, waits until `cond_out` has risen, and then holds `clr_main` high for exactly the next edge, which is the edge at which the flag register captures the rising edge. The flag is judged set after that edge, and a later lone clear pulse is judged to drop it.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;

  localparam int CTL_W   = 16;
  localparam int STAT_IX = 15;

  // Writable control bits 10:0, MSB first
  typedef struct packed {
    logic       rlvl;   // bit 10 manual reference level
    logic       rman;   // bit 9  manual reference mode
    logic       esel;   // bit 8  edge select
    logic [1:0] pmode;  // bits 7:6 power mode
    logic [1:0] fdly;   // bits 5:4 filter delay select
    logic       fen;    // bit 3  filter enable
    logic       pol;    // bit 2  output polarity
    logic       exch;   // bit 1  input exchange
    logic       en;     // bit 0  block enable
  } ctl_t;

  localparam int CTL_BITS = $bits(ctl_t);

  localparam logic [1:0] PM_FAST = 2'b00;
  localparam logic [1:0] PM_NORM = 2'b01;

  function automatic logic filt_allowed(input logic [1:0] pm);
    return (pm == PM_FAST) || (pm == PM_NORM);
  endfunction

endpackage

// File: rtl/cmp_sync2.sv
module cmp_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/cmp_glitch_filter.sv
module cmp_glitch_filter #(
  parameter int DLY0 = 7,
  parameter int DLY1 = 14,
  parameter int DLY2 = 29,
  parameter int DLY3 = 58
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] sel,
  input  logic       din,
  output logic       dout
);

  localparam int MAXD = (DLY3 > DLY2) ? DLY3 : DLY2;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    case (sel)
      2'd0:    lim = CW'(DLY0);
      2'd1:    lim = CW'(DLY1);
      2'd2:    lim = CW'(DLY2);
      default: lim = CW'(DLY3);
    endcase
  end

  // next-state: restart on agreement, commit after lim disagreeing cycles
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!active) begin
      lvl_d = din;
      cnt_d = '0;
    end else if (din == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q >= lim - CW'(1)) begin
      lvl_d = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign dout = active ? lvl_q : din;

  // R4: no commit while the disagreement is younger than the count
  p_hold_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (din != lvl_q) && (cnt_q < lim - CW'(1))) |=> (lvl_q == $past(lvl_q)));

  // R6: counter never exceeds the longest delay
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXD));

endmodule

// File: rtl/cmp_edge_flags.sv
module cmp_edge_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  input  logic esel,
  input  logic clr_main,
  input  logic clr_inv,
  output logic flag_main,
  output logic flag_inv
);

  logic e_now, e_q;
  logic set_main, set_inv;
  logic fm_d, fi_d;

  // edge select folds into the tracked level, so toggling it looks like an edge
  assign e_now    = lvl ^ esel;
  assign set_main = en &  e_now & ~e_q;
  assign set_inv  = en & ~e_now &  e_q;

  always_comb begin
    fm_d = set_main | (flag_main & ~clr_main);
    fi_d = set_inv  | (flag_inv  & ~clr_inv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q       <= 1'b0;
      flag_main <= 1'b0;
      flag_inv  <= 1'b0;
    end else begin
      e_q       <= e_now;
      flag_main <= fm_d;
      flag_inv  <= fi_d;
    end
  end

  // R9: sticky without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_main && !clr_main) |=> flag_main);

  // R9: set beats a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_inv && clr_inv) |=> flag_inv);

  // R12: nothing sets while disabled
  p_off_noflag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flag_main) |=> !flag_main);

endmodule

// File: rtl/cmp_out_cond.sv
module cmp_out_cond
  import cmp_cond_pkg::*;
#(
  parameter int DLY0 = 7,
  parameter int DLY1 = 14,
  parameter int DLY2 = 29,
  parameter int DLY3 = 58,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic [1:0]       ref_src,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             clr_main,
  input  logic             clr_inv,
  output logic             cond_out,
  output logic             flag_main,
  output logic             flag_inv,
  output logic             ref_sel
);

  localparam int RSV_W = STAT_IX - CTL_BITS;

  ctl_t ctl_q, ctl_d;
  logic raw_s, xch_lvl, filt_lvl, pol_lvl;
  logic out_q, out_d;
  logic filt_on, ref_pick;

  // control register
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) ctl_d = ctl_t'(ctl_wdata[CTL_BITS-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  cmp_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(raw_s)
  );

  assign xch_lvl = raw_s ^ ctl_q.exch;
  assign filt_on = ctl_q.fen & filt_allowed(ctl_q.pmode);

  cmp_glitch_filter #(
    .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .active(filt_on), .sel(ctl_q.fdly),
    .din(xch_lvl), .dout(filt_lvl)
  );

  assign pol_lvl = filt_lvl ^ ctl_q.pol;
  assign out_d   = ctl_q.en & pol_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign cond_out = out_q;

  cmp_edge_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .lvl(out_q), .esel(ctl_q.esel),
    .clr_main(clr_main), .clr_inv(clr_inv),
    .flag_main(flag_main), .flag_inv(flag_inv)
  );

  assign ref_pick  = ctl_q.rman ? ctl_q.rlvl : out_q;
  assign ref_sel   = (ref_src != 2'b11) & ref_pick;
  assign ctl_rdata = {out_q, {RSV_W{1'b0}}, ctl_q};

  // R12: disabled block drives a low output
  p_off_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.en |=> !cond_out);

  // R11: no reference switching for the external source code
  p_ref_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_src == 2'b11) |-> !ref_sel);

  // R10: automatic hysteresis tracks the output
  p_ref_auto_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ref_src != 2'b11) && !ctl_q.rman) |-> (ref_sel == cond_out));

endmodule

// File: tb/cmp_out_cond_test.sv
`timescale 1ns/1ps
module cmp_out_cond_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_raw;
  logic [1:0]  ref_src;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic [15:0] ctl_rdata;
  logic        clr_main, clr_inv;
  logic        cond_out, flag_main, flag_inv, ref_sel;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cmp_out_cond uut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .ref_src(ref_src),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .clr_main(clr_main), .clr_inv(clr_inv), .cond_out(cond_out),
    .flag_main(flag_main), .flag_inv(flag_inv), .ref_sel(ref_sel)
  );

  // {ctrl[15:0], raw, expected cond_out}; bit0 en, bit1 exch, bit2 pol,
  // bit3 filter enable, bits7:6 power mode
  localparam logic [17:0] VEC [10] = '{
    {16'h0001, 1'b0, 1'b0},  // R1 plain
    {16'h0001, 1'b1, 1'b1},  // R1 plain
    {16'h0003, 1'b1, 1'b0},  // R2 exchange
    {16'h0003, 1'b0, 1'b1},  // R2 exchange
    {16'h0005, 1'b1, 1'b0},  // R3 polarity
    {16'h0007, 1'b1, 1'b1},  // R2 + R3 cancel
    {16'h0001, 1'b0, 1'b0},
    {16'h0089, 1'b1, 1'b1},  // R5 mode 10 bypasses filter
    {16'h00C9, 1'b0, 1'b0},  // R5 mode 11 bypasses filter
    {16'h0000, 1'b1, 1'b0}   // R12 disabled
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    ctl_wdata = v;
    ctl_we    = 1'b1;
    tick();
    ctl_we    = 1'b0;
  endtask

  task automatic clr_both();
    clr_main = 1'b1;
    clr_inv  = 1'b1;
    tick();
    clr_main = 1'b0;
    clr_inv  = 1'b0;
  endtask

  // filter delay step: raw moves to nv, output must follow at lim+3 edges
  task automatic filt_step(input logic [1:0] sel, input int lim, input logic nv);
    wr(16'h0009 | (16'(sel) << 4));
    tick();
    tick();
    cmp_raw = nv;
    repeat (lim + 2) tick();
    chk("R6 before count", 16'(cond_out), 16'(!nv));
    tick();
    chk("R6 at count", 16'(cond_out), 16'(nv));
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmp_raw = 1'b0; ref_src = 2'b00; ctl_we = 1'b0;
    ctl_wdata = '0; clr_main = 1'b0; clr_inv = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("reset out", 16'(cond_out), 16'h0);
    chk("reset flags", 16'({flag_main, flag_inv}), 16'h0);
    chk("reset rdata R13", ctl_rdata, 16'h0000);
    chk("reset ref R10", 16'(ref_sel), 16'h0);

    // table walk: R1 R2 R3 R5 R12
    for (int i = 0; i < 10; i++) begin
      ctl_wdata = VEC[i][17:2];
      ctl_we    = 1'b1;
      cmp_raw   = VEC[i][1];
      tick();
      ctl_we    = 1'b0;
      tick();
      tick();
      chk($sformatf("table %0d R2 R3 R5 R12", i), 16'(cond_out), 16'(VEC[i][0]));
      chk($sformatf("table %0d status R13", i), 16'(ctl_rdata[15]), 16'(VEC[i][0]));
    end

    // R1 exact latency
    wr(16'h0001);
    repeat (3) tick();
    chk("R1 settled", 16'(cond_out), 16'h1);
    cmp_raw = 1'b0;
    tick(); tick();
    chk("R1 two edges", 16'(cond_out), 16'h1);
    tick();
    chk("R1 third edge", 16'(cond_out), 16'h0);

    // R4 R6 filter delays
    filt_step(2'd0, 7,  1'b1);
    filt_step(2'd1, 14, 1'b0);
    filt_step(2'd2, 29, 1'b1);
    filt_step(2'd3, 58, 1'b0);

    // R4 short glitch rejected
    begin
      int hi_seen = 0;
      wr(16'h0009);
      tick();
      cmp_raw = 1'b1;
      repeat (6) begin tick(); if (cond_out) hi_seen++; end
      cmp_raw = 1'b0;
      repeat (20) begin tick(); if (cond_out) hi_seen++; end
      chk("R4 glitch ignored", 16'(hi_seen), 16'h0);
    end

    // R4 R5 filter also active in normal mode (01)
    wr(16'h0049);
    tick();
    cmp_raw = 1'b1;
    repeat (3) tick();
    chk("R5 mode 01 filtered", 16'(cond_out), 16'h0);
    repeat (7) tick();
    chk("R4 mode 01 committed", 16'(cond_out), 16'h1);

    // flags: R9 set and clear in the same cycle
    wr(16'h0001);
    cmp_raw = 1'b0;
    repeat (4) tick();
    clr_both();
    chk("R9 cleared", 16'({flag_main, flag_inv}), 16'h0);
    cmp_raw = 1'b1;
    repeat (3) tick();
    clr_main = 1'b1;
    tick();
    clr_main = 1'b0;
    chk("R9 set wins over clear", 16'(flag_main), 16'h1);
    chk("R7 inv quiet on rise", 16'(flag_inv), 16'h0);
    clr_main = 1'b1;
    tick();
    clr_main = 1'b0;
    chk("R9 lone clear", 16'(flag_main), 16'h0);
    cmp_raw = 1'b0;
    repeat (4) tick();
    chk("R7 fall sets inv", 16'({flag_main, flag_inv}), 16'h1);
    clr_both();

    // R8 edge-select write on low output
    wr(16'h0101);
    tick();
    chk("R8 apparent edge", 16'(flag_main), 16'h1);
    clr_both();
    cmp_raw = 1'b1;
    repeat (4) tick();
    chk("R7 swapped rise", 16'({flag_main, flag_inv}), 16'h1);
    cmp_raw = 1'b0;
    repeat (4) tick();
    chk("R7 swapped fall", 16'(flag_main), 16'h1);

    // R12 disabled: no output, no flags
    wr(16'h0000);
    tick();
    clr_both();
    cmp_raw = 1'b1;
    repeat (6) tick();
    chk("R12 out low", 16'(cond_out), 16'h0);
    cmp_raw = 1'b0;
    repeat (6) tick();
    chk("R12 no flags", 16'({flag_main, flag_inv}), 16'h0);

    // R10 R11 reference select
    wr(16'h0001);
    cmp_raw = 1'b1;
    repeat (3) tick();
    chk("R10 auto follows high", 16'(ref_sel), 16'h1);
    cmp_raw = 1'b0;
    repeat (3) tick();
    chk("R10 auto follows low", 16'(ref_sel), 16'h0);
    wr(16'h0601);
    chk("R10 manual level 1", 16'(ref_sel), 16'h1);
    wr(16'h0201);
    chk("R10 manual level 0", 16'(ref_sel), 16'h0);
    wr(16'h0601);
    ref_src = 2'b11;
    #1;
    chk("R11 source 11", 16'(ref_sel), 16'h0);
    ref_src = 2'b00;

    // R13 readback
    wr(16'hFFFF);
    tick(); tick();
    chk("R13 rdata low out", ctl_rdata, 16'h07FF);
    cmp_raw = 1'b1;
    repeat (3) tick();
    chk("R13 rdata high out", ctl_rdata, 16'h87FF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule